// File: doc/BRIEF.md
# Accelerator Run-Control Sequencer

This block governs the run lifecycle of a small programmable accelerator core. A host loads a start address and pulses a start strobe. The sequencer then loads the program counter and waits for the random-number source to report that its reseed has finished. It holds for one more cycle and then enables instruction fetch. From that point the host sees the core as busy, with a cleared instruction counter and cleared error bits.

While the core runs, the datapath reports each retired instruction. It may also request a jump, signal an end of program, or raise error bits. The sequencer works out the following program counter, which is either the current one plus 4 or the jump target. It checks that address for alignment and range. It then tells the datapath whether to commit or abort that instruction's pending updates. On an error it aborts the instruction, and the instruction counter does not advance. On a clean end of program the instruction commits and is counted. Either kind of halt sets the done flag, clears busy, stores the error bits and records the address of the halting instruction.

Top module: `runctl_top`

## Requirements
- R1: After reset, busy, done, fetch enable, commit and abort are 0, and the error bits, instruction counter, program counter and stop address are all zero.
- R2: A start strobe while idle loads the program counter from the start address. Fetch enable stays low until reseed-done has been sampled high. It rises one cycle after that sample.
- R3: Busy set, done clear, instruction counter cleared and error bits cleared all become visible in the same cycle that fetch enable first rises. Before that cycle, the values from the previous run remain visible.
- R4: The next program counter is the current program counter plus 4. When jump is asserted on a retiring instruction, the jump target replaces it for that instruction only.
- R5: If the next program counter has bit 1 or bit 0 set, or is at or above IMEM_BYTES (4096), error bit 0 (bad instruction address) is raised for that instruction.
- R6: Each retiring instruction that is not stalled and has no error pulses commit for that cycle and increments the instruction counter by one.
- R7: A retiring instruction with any error bit pulses abort, with commit low. It leaves the instruction counter and program counter unchanged. It stores the OR of the datapath error bits and the bad-address bit.
- R8: Every halt, whether from an error or from end of program, sets done, clears busy, drops fetch enable and records the halting instruction's program counter as the stop address.
- R9: An end-of-program instruction with no error commits, increments the counter and halts with all error bits zero.
- R10: A retire reported while stall is high is ignored: no commit, no abort, no count, and the program counter holds.
- R11: A start strobe is ignored while a run is in progress. Error bits and the stop address keep their values until the next run goes live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Host start strobe |
| start_addr_i | input | PC_W | Host start address |
| reseed_done_i | input | 1 | Random source reseed finished |
| retire_i | input | 1 | Datapath reports an executed instruction |
| stall_i | input | 1 | Datapath stall |
| jump_i | input | 1 | Jump or loop-back request for this instruction |
| jump_pc_i | input | PC_W | Jump target |
| end_i | input | 1 | End-of-program request |
| err_i | input | ERR_W | Datapath error bits for this instruction |
| fetch_en_o | output | 1 | Instruction fetch enable |
| pc_o | output | PC_W | Current program counter |
| commit_o | output | 1 | Commit pending updates of this instruction |
| abort_o | output | 1 | Discard pending updates of this instruction |
| busy_o | output | 1 | Host status: busy |
| done_o | output | 1 | Host interrupt state: done |
| err_bits_o | output | ERR_W | Host error register |
| insn_cnt_o | output | CNT_W | Host instruction counter |
| stop_pc_o | output | PC_W | Program counter of halting instruction |

## Verification
The hardest window to reach is the stretch between a new start and its go-live cycle. During that stretch the previous run's error bits, done flag and count must stay visible. Any early clear shows up only if the run before it ended in an error. The stimulus therefore halts a run on a datapath error and then starts again with reseed-done held low for several cycles, sampling the host registers in each of those cycles. The bad-address path is reached three ways: a misaligned jump, a jump past the memory limit, and a plain plus-4 step from the last word.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_SEED = 2'd1,
    ST_WARM      = 2'd2,
    ST_RUN       = 2'd3
  } run_state_e;
endpackage

// File: rtl/runctl_nextpc.sv
module runctl_nextpc #(
  parameter int PC_W       = 16,
  parameter int IMEM_BYTES = 4096
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            jump_i,
  input  logic [PC_W-1:0] jump_pc_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            bad_o
);
  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(IMEM_BYTES);
  localparam logic [PC_W:0] STEP  = (PC_W+1)'(4);

  logic [PC_W:0] wide;

  always_comb begin
    wide      = jump_i ? {1'b0, jump_pc_i} : ({1'b0, pc_i} + STEP);
    next_pc_o = wide[PC_W-1:0];
    bad_o     = (wide[1:0] != 2'b00) || (wide >= LIMIT);
  end
endmodule

// File: rtl/runctl_seq.sv
module runctl_seq
  import runctl_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [PC_W-1:0] start_addr_i,
  input  logic            reseed_done_i,
  input  logic            retire_i,
  input  logic            stall_i,
  input  logic            end_i,
  input  logic            err_any_i,
  input  logic [PC_W-1:0] next_pc_i,
  output run_state_e      state_o,
  output logic [PC_W-1:0] pc_o,
  output logic            go_live_o,
  output logic            step_o,
  output logic            halt_o,
  output logic            err_halt_o
);
  run_state_e      state_q;
  logic [PC_W-1:0] pc_q;

  always_comb begin
    go_live_o  = (state_q == ST_WARM);
    step_o     = (state_q == ST_RUN) && retire_i && !stall_i;
    err_halt_o = step_o && err_any_i;
    halt_o     = step_o && (err_any_i || end_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT_SEED;
          pc_q    <= start_addr_i;
        end
        ST_WAIT_SEED: if (reseed_done_i) state_q <= ST_WARM;
        ST_WARM: state_q <= ST_RUN;
        ST_RUN: begin
          if (halt_o)      state_q <= ST_IDLE;
          else if (step_o) pc_q    <= next_pc_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign pc_o    = pc_q;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && stall_i) |=> $stable(pc_q));
  // R2
  seed_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_SEED && !reseed_done_i) |=> (state_q == ST_WAIT_SEED));
  // R2
  warm_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM) |=> (state_q == ST_RUN));
endmodule

// File: rtl/runctl_hostregs.sv
module runctl_hostregs #(
  parameter int PC_W  = 16,
  parameter int ERR_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_live_i,
  input  logic             step_i,
  input  logic             halt_i,
  input  logic             err_halt_i,
  input  logic [ERR_W-1:0] err_bits_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_bits_o,
  output logic [CNT_W-1:0] insn_cnt_o,
  output logic [PC_W-1:0]  stop_pc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      err_bits_o <= '0;
      insn_cnt_o <= '0;
      stop_pc_o  <= '0;
    end else if (go_live_i) begin
      busy_o     <= 1'b1;
      done_o     <= 1'b0;
      err_bits_o <= '0;
      insn_cnt_o <= '0;
    end else begin
      if (step_i && !err_halt_i) insn_cnt_o <= insn_cnt_o + 1'b1;
      if (err_halt_i)            err_bits_o <= err_bits_i;
      if (halt_i) begin
        busy_o    <= 1'b0;
        done_o    <= 1'b1;
        stop_pc_o <= pc_i;
      end
    end
  end

  // R8
  halt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    halt_i |=> (!busy_o && done_o));
  // R7
  err_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    err_halt_i |=> $stable(insn_cnt_o));
  // R3
  go_live_chk: assert property (@(posedge clk) disable iff (rst)
    go_live_i |=> (busy_o && insn_cnt_o == '0 && err_bits_o == '0));
endmodule

// File: rtl/runctl_top.sv
module runctl_top
  import runctl_pkg::*;
#(
  parameter int PC_W       = 16,
  parameter int IMEM_BYTES = 4096,
  parameter int ERR_W      = 8,
  parameter int CNT_W      = 32,
  parameter int BAD_BIT    = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [PC_W-1:0]  start_addr_i,
  input  logic             reseed_done_i,
  input  logic             retire_i,
  input  logic             stall_i,
  input  logic             jump_i,
  input  logic [PC_W-1:0]  jump_pc_i,
  input  logic             end_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             fetch_en_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             commit_o,
  output logic             abort_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_bits_o,
  output logic [CNT_W-1:0] insn_cnt_o,
  output logic [PC_W-1:0]  stop_pc_o
);
  localparam logic [ERR_W-1:0] BAD_MASK = ERR_W'(1) << BAD_BIT;

  logic [PC_W-1:0]  next_pc;
  logic             bad_addr;
  logic [ERR_W-1:0] err_all;
  run_state_e       state;
  logic             go_live, step, halt, err_halt;

  runctl_nextpc #(.PC_W(PC_W), .IMEM_BYTES(IMEM_BYTES)) u_nextpc (
    .pc_i      (pc_o),
    .jump_i    (jump_i),
    .jump_pc_i (jump_pc_i),
    .next_pc_o (next_pc),
    .bad_o     (bad_addr)
  );

  assign err_all = err_i | (bad_addr ? BAD_MASK : '0);

  runctl_seq #(.PC_W(PC_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .start_addr_i  (start_addr_i),
    .reseed_done_i (reseed_done_i),
    .retire_i      (retire_i),
    .stall_i       (stall_i),
    .end_i         (end_i),
    .err_any_i     (err_all != '0),
    .next_pc_i     (next_pc),
    .state_o       (state),
    .pc_o          (pc_o),
    .go_live_o     (go_live),
    .step_o        (step),
    .halt_o        (halt),
    .err_halt_o    (err_halt)
  );

  runctl_hostregs #(.PC_W(PC_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .go_live_i  (go_live),
    .step_i     (step),
    .halt_i     (halt),
    .err_halt_i (err_halt),
    .err_bits_i (err_all),
    .pc_i       (pc_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_bits_o (err_bits_o),
    .insn_cnt_o (insn_cnt_o),
    .stop_pc_o  (stop_pc_o)
  );

  assign fetch_en_o = (state == ST_RUN);
  assign commit_o   = step && !err_halt;
  assign abort_o    = err_halt;

  // R7
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && abort_o));
  // R8
  halt_drops_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_o || (commit_o && end_i)) |=> !fetch_en_o);
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_o && fetch_en_o) |=> (insn_cnt_o == $past(insn_cnt_o) + 1'b1));
endmodule

// File: tb/runctl_top_tb.sv
module runctl_top_tb;
  localparam int PC_W = 16;
  localparam int ERR_W = 8;
  localparam int CNT_W = 32;

  typedef struct {
    string           tag;
    logic            fetch;
    logic [PC_W-1:0] pc;
    logic            busy;
    logic            done;
    logic [ERR_W-1:0] err;
    logic [CNT_W-1:0] cnt;
    logic [PC_W-1:0] stop;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, reseed_done_i = 0, retire_i = 0, stall_i = 0, jump_i = 0, end_i = 0;
  logic [PC_W-1:0] start_addr_i = '0, jump_pc_i = '0;
  logic [ERR_W-1:0] err_i = '0;
  logic fetch_en_o, commit_o, abort_o, busy_o, done_o;
  logic [PC_W-1:0] pc_o, stop_pc_o;
  logic [ERR_W-1:0] err_bits_o;
  logic [CNT_W-1:0] insn_cnt_o;

  always #2 clk = ~clk;

  runctl_top u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .reseed_done_i(reseed_done_i), .retire_i(retire_i), .stall_i(stall_i),
    .jump_i(jump_i), .jump_pc_i(jump_pc_i), .end_i(end_i), .err_i(err_i),
    .fetch_en_o(fetch_en_o), .pc_o(pc_o), .commit_o(commit_o), .abort_o(abort_o),
    .busy_o(busy_o), .done_o(done_o), .err_bits_o(err_bits_o),
    .insn_cnt_o(insn_cnt_o), .stop_pc_o(stop_pc_o)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 0;
  exp_t q[$];

  // model state: 0 idle, 1 wait seed, 2 warm, 3 run
  int               m_st = 0;
  logic [PC_W-1:0]  m_pc = '0, m_stop = '0;
  logic             m_busy = 0, m_done = 0;
  logic [ERR_W-1:0] m_err = '0;
  logic [CNT_W-1:0] m_cnt = '0;

  task automatic chk1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares registered outputs one cycle after each driven vector
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        int bad0;
        e = q.pop_front();
        bad0 = n_bad;
        if (fetch_en_o !== e.fetch) begin n_bad++; $display("FAIL %s fetch actual=%0h expected=%0h", e.tag, fetch_en_o, e.fetch); end
        if (pc_o !== e.pc)          begin n_bad++; $display("FAIL %s pc actual=%0h expected=%0h", e.tag, pc_o, e.pc); end
        if (busy_o !== e.busy)      begin n_bad++; $display("FAIL %s busy actual=%0h expected=%0h", e.tag, busy_o, e.busy); end
        if (done_o !== e.done)      begin n_bad++; $display("FAIL %s done actual=%0h expected=%0h", e.tag, done_o, e.done); end
        if (err_bits_o !== e.err)   begin n_bad++; $display("FAIL %s err actual=%0h expected=%0h", e.tag, err_bits_o, e.err); end
        if (insn_cnt_o !== e.cnt)   begin n_bad++; $display("FAIL %s cnt actual=%0h expected=%0h", e.tag, insn_cnt_o, e.cnt); end
        if (stop_pc_o !== e.stop)   begin n_bad++; $display("FAIL %s stop_pc actual=%0h expected=%0h", e.tag, stop_pc_o, e.stop); end
        n_vec++;
        if (n_bad > bad0) n_bad = bad0 + 1;
      end
    end
  end

  // driver: one clock cycle of stimulus, expected post-edge state queued
  task automatic cyc(input logic st, input logic [PC_W-1:0] sa, input logic rs,
                     input logic rt, input logic stl, input logic jv,
                     input logic [PC_W-1:0] jpc, input logic en,
                     input logic [ERR_W-1:0] er, input string tag);
    logic ec, ea;
    logic [PC_W:0] nxt;
    logic [ERR_W-1:0] e;
    exp_t x;
    @(negedge clk);
    start_i = st; start_addr_i = sa; reseed_done_i = rs; retire_i = rt;
    stall_i = stl; jump_i = jv; jump_pc_i = jpc; end_i = en; err_i = er;
    ec = 0; ea = 0;
    case (m_st)
      0: if (st) begin m_st = 1; m_pc = sa; end
      1: if (rs) m_st = 2;
      2: begin m_st = 3; m_busy = 1; m_done = 0; m_cnt = '0; m_err = '0; end
      default: if (rt && !stl) begin
        nxt = jv ? {1'b0, jpc} : ({1'b0, m_pc} + 17'd4);
        e = er | ((nxt[1:0] != 0 || nxt >= 17'd4096) ? 8'h01 : 8'h00);
        if (e != 0) begin
          ea = 1; m_err = e; m_busy = 0; m_done = 1; m_stop = m_pc; m_st = 0;
        end else begin
          ec = 1; m_cnt = m_cnt + 1;
          if (en) begin m_busy = 0; m_done = 1; m_stop = m_pc; m_st = 0; end
          else m_pc = nxt[PC_W-1:0];
        end
      end
    endcase
    #1;
    chk1(tag, "commit", {31'd0, commit_o}, {31'd0, ec});
    chk1(tag, "abort", {31'd0, abort_o}, {31'd0, ea});
    x.tag = tag; x.fetch = (m_st == 3); x.pc = m_pc; x.busy = m_busy; x.done = m_done;
    x.err = m_err; x.cnt = m_cnt; x.stop = m_stop;
    q.push_back(x);
  endtask

  task automatic idle(input string tag);
    cyc(0, '0, 0, 0, 0, 0, '0, 0, '0, tag);
  endtask
  task automatic run(input logic jv, input logic [PC_W-1:0] jpc, input logic en,
                     input logic [ERR_W-1:0] er, input string tag);
    cyc(0, '0, 0, 1, 0, jv, jpc, en, er, tag);
  endtask
  task automatic launch(input logic [PC_W-1:0] a, input int waits, input string tag);
    cyc(1, a, 0, 0, 0, 0, '0, 0, '0, tag);
    for (int i = 0; i < waits; i++) idle(tag);
    cyc(0, '0, 1, 0, 0, 0, '0, 0, '0, tag);
    idle(tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    #1;
    chk1("R1", "busy", {31'd0, busy_o}, 0);
    chk1("R1", "done", {31'd0, done_o}, 0);
    chk1("R1", "fetch", {31'd0, fetch_en_o}, 0);
    chk1("R1", "pc", {16'd0, pc_o}, 0);
    chk1("R1", "err", {24'd0, err_bits_o}, 0);
    chk1("R1", "cnt", insn_cnt_o, 0);
    chk1("R1", "stop", {16'd0, stop_pc_o}, 0);
    // R2 R3 start with reseed delay; retire while waiting is ignored
    cyc(1, 16'h0100, 0, 0, 0, 0, '0, 0, '0, "R2_start");
    cyc(0, '0, 0, 1, 0, 0, '0, 0, '0, "R2_wait");
    idle("R2_wait"); idle("R3_prelive");
    cyc(0, '0, 1, 0, 0, 0, '0, 0, '0, "R2_seed");
    idle("R3_live");
    // R4 R6 sequential
    run(0, '0, 0, '0, "R4_seq");
    run(0, '0, 0, '0, "R6_count");
    // R10 stall
    cyc(0, '0, 0, 1, 1, 0, '0, 0, '0, "R10_stall");
    // R4 jump then default again
    run(1, 16'h0040, 0, '0, "R4_jump");
    run(0, '0, 0, '0, "R4_after_jump");
    // R11 start while busy
    cyc(1, 16'h0800, 0, 0, 0, 0, '0, 0, '0, "R11_start_busy");
    // R9 clean end
    run(0, '0, 1, '0, "R9_end");
    idle("R8_idle");
    // R7 datapath error
    launch(16'h0200, 0, "R2_second");
    run(0, '0, 0, '0, "R6_second");
    run(0, '0, 0, 8'h08, "R7_err");
    idle("R8_after_err");
    // R11 R3 error held until go-live
    launch(16'h0300, 4, "R11_err_held");
    run(1, 16'h0042, 0, '0, "R5_misaligned");
    launch(16'h0010, 1, "R5_restart");
    run(1, 16'h1000, 0, 8'h04, "R5_range");
    // R5 plus-4 off the end, with end request: error wins
    launch(16'h0FF8, 0, "R5_lastword");
    run(0, '0, 0, '0, "R5_step");
    run(0, '0, 1, '0, "R5_end_bad");
    idle("R8_final");
    idle("R8_final");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule